// File: doc/BRIEF.md
# Flag-Selective Integer ALU

This block is the 32-bit integer execution unit of a load/store core. Operand A is the value of the destination register. Operand B is either a second register value or a 15-bit immediate. The block covers addition, subtraction, increment, decrement, multiplication, bitwise logic, three kinds of shift, and signed and unsigned comparison. It returns a result and a write enable for the register file.

Alongside the result it returns one update enable and one new value per status flag. Each operation changes only the flags in its own update set. The block also keeps the current status word itself: a flag outside the update set of an operation keeps the value it had before.

Operations are accepted with a valid strobe on any cycle, back to back. Every output is registered, so the effects of an operation appear exactly one clock later.

Top module: `alu_flagged`

## Requirements
- R1: While reset is asserted and after it is released, before any operation, `valid_o`, `wr_en_o`, `flag_upd_o`, `flag_new_o` and `flags_o` are all zero.
- R2: An operation presented with `valid_i` high at a rising edge produces `valid_o` high with its result and flag outputs after that same edge. A cycle with `valid_i` low produces `valid_o`, `wr_en_o` and `flag_upd_o` all low.
- R3: With `use_imm_i` high, operand B is `imm_i` sign-extended to 32 bits, except for the unsigned compare, where it is zero-extended. With `use_imm_i` low, operand B is `b_reg_i`.
- R4: add returns A+B, sub returns A-B, inc returns A+1 and dec returns A-1, all modulo 2^32. The O flag is set when the signed result of add, inc or dec overflows.
- R5: mul returns the low 32 bits of the signed product. O is set when the full 64-bit signed product does not fit in 32 signed bits.
- R6: and, or and xor combine A with B bit by bit, and not returns the inverse of A.
- R7: shl and shr shift A logically left and right, and sar shifts A right while copying bit 31. All three shift by B[4:0] only, so an amount of 33 shifts by 1.
- R8: Flag bit positions in `flag_upd_o`, `flag_new_o` and `flags_o` are E=3, Z=2, O=1, S=0. add, inc, dec and mul update Z, O and S. sub and the logic and shift operations update Z and S. Both compares update E, Z and S. Codes 14 and 15 update no flag and write nothing.
- R9: For operations that write a result, the new Z value is 1 when the result is zero, and the new S value is bit 31 of the result.
- R10: A compare does not write a result. It sets Z when A equals B, sets E when A equals B and A is zero, and sets S when A is below B. cmp uses signed ordering and cmpu uses unsigned ordering.
- R11: A flag outside an operation's update set keeps its previous value in `flags_o`. A flag inside the set takes the value shown on `flag_new_o`.
- R12: Operation codes on `op_i` are: add 0, sub 1, inc 2, dec 3, mul 4, and 5, or 6, xor 7, not 8, shl 9, shr 10, sar 11, cmp 12, cmpu 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A (destination register value) |
| b_reg_i | input | 32 | Operand B register value |
| imm_i | input | 15 | Immediate operand |
| use_imm_i | input | 1 | Select the immediate as operand B |
| valid_o | output | 1 | Registered outputs carry an operation |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Write the result to the destination |
| flag_upd_o | output | 4 | Per-flag update enable |
| flag_new_o | output | 4 | New flag values, zero where not updated |
| flags_o | output | 4 | Current status flags |

## Verification
The bench goes after the overflow boundaries. A design with a wrong overflow term would miss O on 0x7fffffff+1, on an increment of the largest value, on a decrement of the smallest value, or on a 0x10000 squared product whose low word is zero. It drives a compare with an all-ones immediate both ways. A design that sign-extended the immediate for cmpu would report the wrong S, and a design that set E on equality alone would flag a nonzero equal pair. Shift amounts of 32 and above show whether bits above 4 leak into the shifter. Every operation code runs with flags that were already set before it, so a design that clears or rewrites a flag outside the update set shows up as a changed `flags_o`.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_MUL  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NOT  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_SAR  = 4'd11,
    OP_CMP  = 4'd12,
    OP_CMPU = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } op_e;

  localparam int FLAG_N = 4;
  localparam int FLG_E  = 3;
  localparam int FLG_Z  = 2;
  localparam int FLG_O  = 1;
  localparam int FLG_S  = 0;

  localparam logic [FLAG_N-1:0] MASK_ZOS = 4'b0111;
  localparam logic [FLAG_N-1:0] MASK_ZS  = 4'b0101;
  localparam logic [FLAG_N-1:0] MASK_EZS = 4'b1101;

endpackage

// File: rtl/alu_opnd.sv
module alu_opnd
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 15
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] b_reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] b_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx, imm_zx;

  assign imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign imm_zx = {{EXT_W{1'b0}}, imm_i};

  always_comb begin
    if (!use_imm_i)            b_o = b_reg_i;
    else if (op_i == OP_CMPU)  b_o = imm_zx;
    else                       b_o = imm_sx;
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0]        add_b, sum;
  logic                     add_cin, sum_ovf, prod_ovf;
  logic signed [PROD_W-1:0] prod;

  // one adder serves add, sub, inc and dec
  always_comb begin
    add_cin = 1'b0;
    unique case (op_i)
      OP_SUB:  begin add_b = ~b_i; add_cin = 1'b1; end
      OP_INC:  add_b = {{(DATA_W-1){1'b0}}, 1'b1};
      OP_DEC:  add_b = '1;
      default: add_b = b_i;
    endcase
  end

  assign sum     = a_i + add_b + {{(DATA_W-1){1'b0}}, add_cin};
  assign sum_ovf = (a_i[MSB] == add_b[MSB]) && (sum[MSB] != a_i[MSB]);

  assign prod     = $signed(a_i) * $signed(b_i);
  assign prod_ovf = prod[PROD_W-1:DATA_W] != {DATA_W{prod[MSB]}};

  always_comb begin
    if (op_i == OP_MUL) begin
      res_o = prod[DATA_W-1:0];
      ovf_o = prod_ovf;
    end else begin
      res_o = sum;
      ovf_o = sum_ovf;
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0] shamt;
  assign shamt = b_i[SHAMT_W-1:0];

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SHL:  res_o = a_i << shamt;
      OP_SHR:  res_o = a_i >> shamt;
      OP_SAR:  res_o = $unsigned($signed(a_i) >>> shamt);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              signed_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              eq_o,
  output logic              lt_o,
  output logic              a_zero_o
);
  assign eq_o     = a_i == b_i;
  assign a_zero_o = ~|a_i;
  assign lt_o     = signed_i ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flag_upd_o,
  output logic [3:0]        flag_new_o,
  output logic [3:0]        flags_o
);
  localparam int MSB = DATA_W - 1;

  op_e               op;
  logic [DATA_W-1:0] opnd_b, arith_res, logic_res, res_d;
  logic              arith_ovf, cmp_eq, cmp_lt, a_zero;
  logic              sel_arith, is_cmp, wr_d;
  logic [FLAG_N-1:0] upd_d, val_d, new_d;

  assign op = op_e'(op_i);

  alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_opnd (
    .op_i      (op),
    .b_reg_i   (b_reg_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .b_o       (opnd_b)
  );

  alu_arith #(.DATA_W(DATA_W)) i_arith (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (opnd_b),
    .res_o (arith_res),
    .ovf_o (arith_ovf)
  );

  alu_logic #(.DATA_W(DATA_W)) i_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (opnd_b),
    .res_o (logic_res)
  );

  alu_cmp #(.DATA_W(DATA_W)) i_cmp (
    .signed_i (op == OP_CMP),
    .a_i      (a_i),
    .b_i      (opnd_b),
    .eq_o     (cmp_eq),
    .lt_o     (cmp_lt),
    .a_zero_o (a_zero)
  );

  // per-opcode write and flag update set
  always_comb begin
    sel_arith = 1'b0;
    is_cmp    = 1'b0;
    wr_d      = 1'b1;
    upd_d     = '0;
    unique case (op)
      OP_ADD, OP_INC, OP_DEC, OP_MUL: begin
        sel_arith = 1'b1;
        upd_d     = MASK_ZOS;
      end
      OP_SUB: begin
        sel_arith = 1'b1;
        upd_d     = MASK_ZS;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL, OP_SHR, OP_SAR:
        upd_d = MASK_ZS;
      OP_CMP, OP_CMPU: begin
        is_cmp = 1'b1;
        wr_d   = 1'b0;
        upd_d  = MASK_EZS;
      end
      default: wr_d = 1'b0;
    endcase
  end

  assign res_d = sel_arith ? arith_res : logic_res;

  always_comb begin
    val_d = '0;
    if (is_cmp) begin
      val_d[FLG_E] = cmp_eq & a_zero;
      val_d[FLG_Z] = cmp_eq;
      val_d[FLG_S] = cmp_lt;
    end else begin
      val_d[FLG_Z] = ~|res_d;
      val_d[FLG_O] = arith_ovf;
      val_d[FLG_S] = res_d[MSB];
    end
  end

  assign new_d = val_d & upd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      wr_en_o    <= 1'b0;
      flag_upd_o <= '0;
      flag_new_o <= '0;
      flags_o    <= '0;
    end else if (valid_i) begin
      valid_o    <= 1'b1;
      result_o   <= is_cmp ? result_o : res_d;
      wr_en_o    <= wr_d;
      flag_upd_o <= upd_d;
      flag_new_o <= new_d;
      flags_o    <= (flags_o & ~upd_d) | new_d;
    end else begin
      valid_o    <= 1'b0;
      wr_en_o    <= 1'b0;
      flag_upd_o <= '0;
      flag_new_o <= '0;
    end
  end
endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [3:0]        flag_upd_o,
  input logic [3:0]        flag_new_o,
  input logic [3:0]        flags_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wr_en_o && flag_upd_o == 4'b0)); // R2

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(op_i) == OP_CMP || $past(op_i) == OP_CMPU)) |-> !wr_en_o); // R10

  AST_O_ONLY_ARITH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flag_upd_o[FLG_O]) |-> ($past(op_i) inside {OP_ADD, OP_INC, OP_DEC, OP_MUL})); // R8

  AST_E_ONLY_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flag_upd_o[FLG_E]) |-> ($past(op_i) inside {OP_CMP, OP_CMPU})); // R8

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wr_en_o && flag_upd_o[FLG_Z]) |-> (flag_new_o[FLG_Z] == (result_o == '0))); // R9

  AST_SIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wr_en_o && flag_upd_o[FLG_S]) |-> (flag_new_o[FLG_S] == result_o[DATA_W-1])); // R9

  AST_CMP_E_IMPLIES_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flag_upd_o[FLG_E] && flag_new_o[FLG_E]) |-> flag_new_o[FLG_Z]); // R10

  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o ^ $past(flags_o)) & ~flag_upd_o) == 4'b0); // R11

  AST_FLAGS_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o ^ flag_new_o) & flag_upd_o) == 4'b0); // R11
endmodule

bind alu_flagged alu_flagged_chk #(.DATA_W(DATA_W)) i_alu_flagged_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .flag_upd_o (flag_upd_o),
  .flag_new_o (flag_new_o),
  .flags_o    (flags_o)
);

// File: tb/test_alu_flagged.sv
module test_alu_flagged;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_reg_i = '0;
  logic [14:0] imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic        valid_o, wr_en_o;
  logic [31:0] result_o;
  logic [3:0]  flag_upd_o, flag_new_o, flags_o;

  always #2.5 clk_i = ~clk_i;

  alu_flagged i_alu_flagged (.*);

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [3:0]  upd;
    logic [3:0]  nw;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [3:0]  model_flags = '0;
  int          n_checks = 0, n_errors = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // driver: computes the expected item from the requirements and pushes it
  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [14:0] imm, input bit ui, input string tag);
    logic [31:0] bb, r;
    longint      sa, sb, wide;
    bit          ovf;
    exp_t        e;
    bb = !ui ? b : (op == 4'd13) ? {17'd0, imm} : {{17{imm[14]}}, imm};
    sa = longint'($signed(a));
    sb = longint'($signed(bb));
    r = '0; ovf = 0; wide = 0;
    e.we = 1; e.upd = 4'b0101;
    case (op)
      4'd0: wide = sa + sb;
      4'd1: wide = sa - sb;
      4'd2: wide = sa + 1;
      4'd3: wide = sa - 1;
      4'd4: wide = sa * sb;
      default: ;
    endcase
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4: begin
        r = wide[31:0];
        ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        if (op != 4'd1) e.upd = 4'b0111;
      end
      4'd5:  r = a & bb;
      4'd6:  r = a | bb;
      4'd7:  r = a ^ bb;
      4'd8:  r = ~a;
      4'd9:  r = a << bb[4:0];
      4'd10: r = a >> bb[4:0];
      4'd11: r = $unsigned($signed(a) >>> bb[4:0]);
      4'd12, 4'd13: begin e.we = 0; e.upd = 4'b1101; end
      default: begin e.we = 0; e.upd = 4'b0000; end
    endcase
    if (op == 4'd12 || op == 4'd13) begin
      e.nw[3] = (a == bb) && (a == 0);
      e.nw[2] = (a == bb);
      e.nw[1] = 1'b0;
      e.nw[0] = (op == 4'd12) ? (sa < sb) : (a < bb);
    end else begin
      e.nw = {1'b0, r == 0, ovf, r[31]};
    end
    e.nw &= e.upd;
    e.res = r;
    model_flags = (model_flags & ~e.upd) | e.nw;
    e.fl = model_flags;
    e.tag = tag;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_reg_i = b; imm_i = imm; use_imm_i = ui;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    valid_i = 1'b0;
    if (n > 1) repeat (n - 1) @(negedge clk_i);
  endtask

  // monitor: pops one expected item per valid output
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (valid_o) begin
        if (sb_q.size() == 0) begin
          check(0, "R2", "unexpected valid_o", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(wr_en_o == e.we, e.tag, "wr_en_o", 32'(wr_en_o), 32'(e.we));
          if (e.we) check(result_o == e.res, e.tag, "result_o", result_o, e.res);
          check(flag_upd_o == e.upd, e.tag, "flag_upd_o", 32'(flag_upd_o), 32'(e.upd));
          check(flag_new_o == e.nw, e.tag, "flag_new_o", 32'(flag_new_o), 32'(e.nw));
          check(flags_o == e.fl, e.tag, "flags_o", 32'(flags_o), 32'(e.fl));
        end
      end else begin
        if (wr_en_o || flag_upd_o != 0)
          check(0, "R2", "idle write/update", {28'd0, flag_upd_o}, 32'd0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finished = 1;
      report();
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk_i);
    check(!valid_o && !wr_en_o && flag_upd_o == 0 && flag_new_o == 0 && flags_o == 0,
          "R1", "outputs in reset", {valid_o, wr_en_o, flag_upd_o, flag_new_o, flags_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!valid_o && !wr_en_o && flag_upd_o == 0 && flags_o == 0,
          "R1", "outputs after reset", {valid_o, wr_en_o, flag_upd_o, flags_o}, 0);

    // arithmetic and overflow edges
    send(4'd0, 32'd5, 32'd7, '0, 0, "R4");
    send(4'd0, 32'h7fff_ffff, 32'd1, '0, 0, "R4");
    send(4'd0, 32'd0, 32'd0, 15'h7fff, 1, "R3");
    send(4'd1, 32'd3, 32'd3, '0, 0, "R11");
    send(4'd1, 32'd3, 32'd0, 15'd5, 1, "R4");
    send(4'd2, 32'h7fff_ffff, 32'd0, '0, 0, "R4");
    send(4'd3, 32'h8000_0000, 32'd0, '0, 0, "R4");
    send(4'd3, 32'd1, 32'd0, '0, 0, "R9");
    send(4'd4, 32'd3, 32'hffff_fffc, '0, 0, "R5");
    send(4'd4, 32'h0001_0000, 32'h0001_0000, '0, 0, "R5");
    send(4'd4, 32'hffff_ffff, 32'd0, 15'h7fff, 1, "R5");
    send(4'd4, 32'h8000_0000, 32'hffff_ffff, '0, 0, "R5");
    // logic
    send(4'd5, 32'hf0f0_1234, 32'h0ff0_ff00, '0, 0, "R6");
    send(4'd6, 32'h0000_0000, 32'd0, 15'h4000, 1, "R6");
    send(4'd7, 32'ha5a5_a5a5, 32'ha5a5_a5a5, '0, 0, "R6");
    send(4'd8, 32'h0000_ffff, 32'd0, '0, 0, "R6");
    // shifts
    send(4'd9, 32'h4000_0001, 32'd33, '0, 0, "R7");
    send(4'd10, 32'h8000_0000, 32'd31, '0, 0, "R7");
    send(4'd11, 32'h8000_0000, 32'd4, '0, 0, "R7");
    send(4'd11, 32'h8000_0000, 32'd0, 15'd36, 1, "R7");
    send(4'd10, 32'h1234_5678, 32'd32, '0, 0, "R7");
    // compares
    send(4'd0, 32'h7fff_ffff, 32'd1, '0, 0, "R11");
    send(4'd12, 32'd0, 32'd0, '0, 0, "R10");
    send(4'd12, 32'hffff_ffff, 32'd1, '0, 0, "R10");
    send(4'd13, 32'hffff_ffff, 32'd1, '0, 0, "R10");
    send(4'd12, 32'd5, 32'd0, 15'h7fff, 1, "R3");
    send(4'd13, 32'd5, 32'd0, 15'h7fff, 1, "R3");
    send(4'd13, 32'h0000_7fff, 32'd0, 15'h7fff, 1, "R10");
    // reserved codes do nothing
    send(4'd14, 32'd0, 32'd0, '0, 0, "R8");
    send(4'd15, 32'hffff_ffff, 32'd0, '0, 0, "R8");
    idle(3);
    // every code with flags preset, back to back
    for (int k = 0; k < 6; k++) begin
      for (int op = 0; op < 16; op++) begin
        logic [31:0] a, b;
        seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
        seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
        if (k == 0) a = 32'd0;
        if (k == 1) b = a;
        send(4'd0, 32'h7fff_ffff, 32'd1, '0, 0, "R12");
        send(4'd12, 32'd0, 32'd0, '0, 0, "R12");
        send(op[3:0], a, b, b[14:0], k[0], "R11");
      end
      idle(2);
    end
    idle(3);
    check(sb_q.size() == 0, "R2", "pending results", sb_q.size(), 0);
    finished = 1;
    report();
  end
endmodule